// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block manages the on-chip packet buffer of an Ethernet controller. The buffer is cut into fixed pages (18 by default), and each stored frame occupies a run of adjacent pages. The block tracks which pages are in use and, for each packet number, where its pages start and how many there are. It also holds two queues of packet numbers: one for frames waiting to transmit and one for received frames waiting for the host.

The host sends one command at a time on a small command port. The commands are: allocate, reset, release the oldest received packet, free a chosen packet, and queue a chosen packet for transmit. An allocate command gives its size as a page count minus one. The host works out this field as (frame bytes + 6) >> 8, where the 6 bytes hold a status word, a byte count and a control word. The allocation result is a packet number and a first page, or a failed flag. In both cases the allocation-done status bit is raised, and it stays raised until the host acknowledges it.

The receive side of the MAC pushes packet numbers into the receive queue. The transmit side reports each finished frame. With automatic release on, a frame that went out cleanly has its pages freed at once. Otherwise its number is shown to the host as the last completed transmit.

Top module: `pkt_page_mmu`

The controller has three states. IDLE waits for a command. EXEC carries out the latched command. HOLD keeps busy asserted for the remaining cycles of the fixed command time. The transitions are:
- IDLE to EXEC when `cmd_valid` is seen.
- EXEC to HOLD always.
- HOLD to IDLE when its down-counter reaches zero.

## Requirements
- R1: After reset, `busy` and `alloc_done` are 0, `free_pages` is 18, and both `rx_empty` and `tx_empty` are 1.
- R2: A command accepted at a clock edge holds `busy` high for exactly 4 cycles. A `cmd_valid` seen while `busy` is 1 is ignored.
- R3: Allocate is `cmd_op`=1, and `cmd_pages` is the page count minus one. It grants the lowest-numbered run of free adjacent pages that is long enough, and the lowest packet number not in use. `alloc_pnum`, `alloc_page` and `alloc_failed`=0 are valid one cycle after acceptance, and `free_pages` drops by the page count.
- R4: If no free run is long enough, or no packet number is free, the allocation fails. `alloc_failed` is 1 and `free_pages` is unchanged. A request larger than the buffer fails at once.
- R5: Every allocation, whether it succeeds or fails, sets `alloc_done`. The bit stays 1 until `alloc_ack` is pulsed, and it is 0 in the cycle after the acknowledge.
- R6: Reset command (`cmd_op`=2) frees every page, forgets every packet number and empties both queues.
- R7: Free-packet (`cmd_op`=4) returns the pages of packet number `cmd_pnum`. A number that is not allocated, or is 18 or higher, has no effect.
- R8: Release (`cmd_op`=3) removes the oldest entry of the receive queue and frees that packet's pages. When the receive queue is empty, it has no effect.
- R9: Enqueue (`cmd_op`=5) appends an allocated `cmd_pnum` to the transmit queue. `tx_head_pnum` shows the oldest entry.
- R10: On a `tx_done` pulse, the transmit head is removed. If `tx_ok` and `auto_release` are both 1, its pages are freed. Otherwise `tx_done_pnum` takes that number and its pages stay in use.
- R11: `rx_push` appends `rx_push_pnum` to the receive queue, and `rx_head_pnum` shows the oldest entry that has not been released.
- R12: `free_pages` always equals 18 minus the sum of the page counts of the packets currently allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 none, 1 allocate, 2 reset, 3 release, 4 free, 5 enqueue |
| cmd_pages | input | 5 | Allocation page count minus one |
| cmd_pnum | input | 6 | Selected packet number |
| busy | output | 1 | Command in progress |
| alloc_done | output | 1 | Allocation completed status bit |
| alloc_ack | input | 1 | Clears `alloc_done` |
| alloc_failed | output | 1 | Last allocation failed |
| alloc_pnum | output | 6 | Granted packet number |
| alloc_page | output | 5 | First page of the grant |
| auto_release | input | 1 | Free cleanly sent frames automatically |
| rx_push | input | 1 | Receive side queues a packet |
| rx_push_pnum | input | 6 | Packet number queued by receive side |
| rx_head_pnum | output | 6 | Oldest received packet number |
| rx_empty | output | 1 | Receive queue empty |
| tx_head_pnum | output | 6 | Next packet number to transmit |
| tx_empty | output | 1 | Transmit queue empty |
| tx_done | input | 1 | Transmit side finished the head frame |
| tx_ok | input | 1 | Finished frame went out cleanly |
| tx_done_pnum | output | 6 | Last completed transmit not released |
| free_pages | output | 5 | Count of free pages |

## Verification
A command is accepted at the edge where `cmd_valid` is seen. Its results, the queue heads and `free_pages` all change at the next edge, and `busy` falls at the fourth edge after acceptance. A `tx_done` or `rx_push` pulse shows its effect one edge later. The bench drives inputs on falling edges and waits one falling edge past each of these edges before it samples. For `busy`, it samples after every edge of the window. A bench model of the page map supplies the expected first-fit page, packet number and free count after every step.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RESET   = 3'd2,
        OP_RELEASE = 3'd3,
        OP_FREE    = 3'd4,
        OP_ENQUEUE = 3'd5
    } mmu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_HOLD
    } mmu_state_e;

endpackage

// File: rtl/pkt_mmu_fifo.sv
module pkt_mmu_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/pkt_mmu_fit.sv
module pkt_mmu_fit #(
    parameter int NUM_PAGES = 18,
    parameter int NEED_W    = 6,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_PAGES-1:0] used,
    input  logic [NEED_W-1:0]    need,
    output logic                 found,
    output logic [IDX_W-1:0]     start
);
    logic ok;

    always_comb begin
        found = 1'b0;
        start = '0;
        ok    = 1'b0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            ok = (need != '0) && (s + int'(need) <= NUM_PAGES);
            for (int p = 0; p < NUM_PAGES; p++) begin
                if (p >= s && p < s + int'(need) && used[p]) ok = 1'b0;
            end
            if (ok) begin
                found = 1'b1;
                start = IDX_W'(s);
            end
        end
    end

endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
    import pkt_mmu_pkg::*;
#(
    parameter int NUM_PAGES  = 18,
    parameter int NUM_PKTS   = 18,
    parameter int PNUM_W     = 6,
    parameter int PAGE_FLD_W = 5,
    parameter int BUSY_CYC   = 4,
    localparam int IDX_W     = $clog2(NUM_PAGES),
    localparam int FC_W      = $clog2(NUM_PAGES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [PAGE_FLD_W-1:0] cmd_pages,
    input  logic [PNUM_W-1:0]     cmd_pnum,
    output logic                  busy,
    output logic                  alloc_done,
    input  logic                  alloc_ack,
    output logic                  alloc_failed,
    output logic [PNUM_W-1:0]     alloc_pnum,
    output logic [IDX_W-1:0]      alloc_page,
    input  logic                  auto_release,
    input  logic                  rx_push,
    input  logic [PNUM_W-1:0]     rx_push_pnum,
    output logic [PNUM_W-1:0]     rx_head_pnum,
    output logic                  rx_empty,
    output logic [PNUM_W-1:0]     tx_head_pnum,
    output logic                  tx_empty,
    input  logic                  tx_done,
    input  logic                  tx_ok,
    output logic [PNUM_W-1:0]     tx_done_pnum,
    output logic [FC_W-1:0]       free_pages
);
    localparam int NEED_W = PAGE_FLD_W + 1;
    localparam int HOLD_W = $clog2(BUSY_CYC + 1);

    mmu_state_e              state, state_nx;
    mmu_op_e                 op_q;
    logic [PAGE_FLD_W-1:0]   pages_q;
    logic [PNUM_W-1:0]       pnum_q;
    logic [HOLD_W-1:0]       hold_cnt;

    logic [NUM_PAGES-1:0]    used;
    logic [NUM_PKTS-1:0]     slot_valid;
    logic [IDX_W-1:0]        slot_base [NUM_PKTS];
    logic [NEED_W-1:0]       slot_cnt  [NUM_PKTS];

    logic                    exec, do_reset;
    logic [NEED_W-1:0]       need;
    logic                    fit_found;
    logic [IDX_W-1:0]        fit_start;
    logic                    slot_found;
    logic [PNUM_W-1:0]       slot_pick;
    logic                    alloc_ok;
    logic [NUM_PKTS-1:0]     clr_slot, set_slot;
    logic [NUM_PAGES-1:0]    clr_mask, set_mask;
    logic                    rx_pop, tx_push, tx_pop, auto_free, sel_allocated;
    logic                    rx_full, tx_full;

    function automatic logic [NUM_PAGES-1:0] span(input logic [IDX_W-1:0] b,
                                                  input logic [NEED_W-1:0] c);
        logic [NUM_PAGES-1:0] m;
        for (int p = 0; p < NUM_PAGES; p++)
            m[p] = (p >= int'(b)) && (p < int'(b) + int'(c));
        return m;
    endfunction

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_NOP;
            pages_q  <= '0;
            pnum_q   <= '0;
            hold_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cmd_valid) begin
                op_q    <= mmu_op_e'(cmd_op);
                pages_q <= cmd_pages;
                pnum_q  <= cmd_pnum;
            end
            if (state == ST_EXEC)      hold_cnt <= HOLD_W'(BUSY_CYC - 2);
            else if (state == ST_HOLD) hold_cnt <= hold_cnt - HOLD_W'(1);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) state_nx = ST_EXEC;
            ST_EXEC: state_nx = ST_HOLD;
            ST_HOLD: if (hold_cnt == '0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy       = (state != ST_IDLE);
        free_pages = FC_W'(NUM_PAGES - $countones(used));
    end

    // ---------------- command decode ----------------
    assign exec     = (state == ST_EXEC);
    assign do_reset = exec && op_q == OP_RESET;
    assign need     = NEED_W'(pages_q) + NEED_W'(1);

    pkt_mmu_fit #(.NUM_PAGES(NUM_PAGES), .NEED_W(NEED_W), .IDX_W(IDX_W)) u_fit (
        .used  (used),
        .need  (need),
        .found (fit_found),
        .start (fit_start)
    );

    always_comb begin
        slot_found = 1'b0;
        slot_pick  = '0;
        for (int i = NUM_PKTS - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                slot_found = 1'b1;
                slot_pick  = PNUM_W'(i);
            end
        end
    end

    assign alloc_ok  = exec && op_q == OP_ALLOC && fit_found && slot_found;
    assign rx_pop    = exec && op_q == OP_RELEASE && !rx_empty;
    assign tx_pop    = tx_done && !tx_empty;
    assign auto_free = tx_pop && tx_ok && auto_release;

    always_comb begin
        sel_allocated = 1'b0;
        clr_slot      = '0;
        set_slot      = '0;
        clr_mask      = '0;
        for (int i = 0; i < NUM_PKTS; i++) begin
            if (slot_valid[i] && pnum_q == PNUM_W'(i)) sel_allocated = 1'b1;
            if (slot_valid[i]) begin
                if (exec && op_q == OP_FREE && pnum_q == PNUM_W'(i)) clr_slot[i] = 1'b1;
                if (rx_pop && rx_head_pnum == PNUM_W'(i))            clr_slot[i] = 1'b1;
                if (auto_free && tx_head_pnum == PNUM_W'(i))         clr_slot[i] = 1'b1;
            end
            if (clr_slot[i]) clr_mask = clr_mask | span(slot_base[i], slot_cnt[i]);
            if (alloc_ok && slot_pick == PNUM_W'(i)) set_slot[i] = 1'b1;
        end
        set_mask = alloc_ok ? span(fit_start, need) : '0;
    end

    assign tx_push = exec && op_q == OP_ENQUEUE && sel_allocated;

    // ---------------- page map and results ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used         <= '0;
            slot_valid   <= '0;
            alloc_done   <= 1'b0;
            alloc_failed <= 1'b0;
            alloc_pnum   <= '0;
            alloc_page   <= '0;
            tx_done_pnum <= '0;
        end else begin
            if (do_reset) begin
                used       <= '0;
                slot_valid <= '0;
            end else begin
                used       <= (used & ~clr_mask) | set_mask;
                slot_valid <= (slot_valid & ~clr_slot) | set_slot;
            end
            if (exec && op_q == OP_ALLOC) begin
                alloc_done   <= 1'b1;
                alloc_failed <= !alloc_ok;
                alloc_pnum   <= alloc_ok ? slot_pick : '0;
                alloc_page   <= alloc_ok ? fit_start : '0;
            end else if (alloc_ack) begin
                alloc_done <= 1'b0;
            end
            if (tx_pop && !auto_free && !do_reset) tx_done_pnum <= tx_head_pnum;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PKTS; i++) begin
            if (set_slot[i]) begin
                slot_base[i] <= fit_start;
                slot_cnt[i]  <= need;
            end
        end
    end

    // ---------------- packet number queues ----------------
    pkt_mmu_fifo #(.W(PNUM_W), .DEPTH(NUM_PKTS)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (do_reset),
        .push  (rx_push),
        .din   (rx_push_pnum),
        .pop   (rx_pop),
        .dout  (rx_head_pnum),
        .empty (rx_empty),
        .full  (rx_full)
    );

    pkt_mmu_fifo #(.W(PNUM_W), .DEPTH(NUM_PKTS)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (do_reset),
        .push  (tx_push),
        .din   (pnum_q),
        .pop   (tx_pop),
        .dout  (tx_head_pnum),
        .empty (tx_empty),
        .full  (tx_full)
    );

endmodule

// File: rtl/pkt_mmu_checker.sv
module pkt_mmu_checker #(
    parameter int NUM_PAGES = 18,
    parameter int BUSY_CYC  = 4,
    parameter int FC_W      = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            busy,
    input logic            alloc_done,
    input logic            alloc_ack,
    input logic            alloc_failed,
    input logic            tx_done,
    input logic [FC_W-1:0] free_pages
);
    localparam int BW = $clog2(BUSY_CYC + 2);
    logic [BW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + BW'(1);
        else           busy_len <= '0;
    end

    // R2: a busy window lasts exactly BUSY_CYC cycles
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == BW'(BUSY_CYC));

    // R2: busy only starts from a command strobe
    assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R5: completion bit holds until acknowledged
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done && !alloc_ack |=> alloc_done);

    // R4: a failed grant leaves the free count alone
    assert_fail_keeps_pages_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alloc_done) && alloc_failed && !$past(tx_done) |-> $stable(free_pages));

    // R12: free count never exceeds the buffer
    assert_free_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        free_pages <= FC_W'(NUM_PAGES));

endmodule

bind pkt_page_mmu pkt_mmu_checker #(
    .NUM_PAGES (NUM_PAGES),
    .BUSY_CYC  (BUSY_CYC),
    .FC_W      (FC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .alloc_done   (alloc_done),
    .alloc_ack    (alloc_ack),
    .alloc_failed (alloc_failed),
    .tx_done      (tx_done),
    .free_pages   (free_pages)
);

// File: tb/tb_pkt_page_mmu.sv
`timescale 1ns/1ps
module tb_pkt_page_mmu;
    localparam int NP = 18;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cmd_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [4:0] cmd_pages = 0;
    logic [5:0] cmd_pnum = 0;
    logic       busy, alloc_done, alloc_failed;
    logic       alloc_ack = 0;
    logic [5:0] alloc_pnum;
    logic [4:0] alloc_page;
    logic       auto_release = 1;
    logic       rx_push = 0;
    logic [5:0] rx_push_pnum = 0;
    logic [5:0] rx_head_pnum, tx_head_pnum, tx_done_pnum;
    logic       rx_empty, tx_empty;
    logic       tx_done = 0, tx_ok = 0;
    logic [4:0] free_pages;

    int n_tests = 0, n_fail = 0;

    // model of page map
    bit m_used  [NP];
    bit m_valid [NP];
    int m_base  [NP];
    int m_cnt   [NP];

    always #10 clk = ~clk;

    pkt_page_mmu dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pages(cmd_pages), .cmd_pnum(cmd_pnum), .busy(busy),
        .alloc_done(alloc_done), .alloc_ack(alloc_ack), .alloc_failed(alloc_failed),
        .alloc_pnum(alloc_pnum), .alloc_page(alloc_page), .auto_release(auto_release),
        .rx_push(rx_push), .rx_push_pnum(rx_push_pnum), .rx_head_pnum(rx_head_pnum),
        .rx_empty(rx_empty), .tx_head_pnum(tx_head_pnum), .tx_empty(tx_empty),
        .tx_done(tx_done), .tx_ok(tx_ok), .tx_done_pnum(tx_done_pnum),
        .free_pages(free_pages)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_free();
        int f = NP;
        for (int p = 0; p < NP; p++) if (m_used[p]) f--;
        return f;
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < NP; i++) begin m_used[i] = 0; m_valid[i] = 0; end
    endfunction

    function automatic void m_release(input int pn);
        if (pn < NP && m_valid[pn]) begin
            for (int p = m_base[pn]; p < m_base[pn] + m_cnt[pn]; p++) m_used[p] = 0;
            m_valid[pn] = 0;
        end
    endfunction

    task automatic cmd(input int op, input int pages, input int pn);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_pages = 5'(pages); cmd_pnum = 6'(pn);
        @(negedge clk);
        cmd_valid = 0;
        repeat (4) @(negedge clk);
    endtask

    // R3 / R4 / R5 / R12: allocate against model
    task automatic alloc_chk(input int need);
        int pg = -1, pn = -1;
        for (int s = 0; s + need <= NP && pg < 0; s++) begin
            bit ok = 1;
            for (int p = s; p < s + need; p++) if (m_used[p]) ok = 0;
            if (ok) pg = s;
        end
        for (int i = 0; i < NP && pn < 0; i++) if (!m_valid[i]) pn = i;
        if (pg >= 0 && pn >= 0) begin
            m_valid[pn] = 1; m_base[pn] = pg; m_cnt[pn] = need;
            for (int p = pg; p < pg + need; p++) m_used[p] = 1;
        end
        cmd(1, need - 1, 0);
        chk("R5 done set", alloc_done, 1);
        if (pg >= 0 && pn >= 0) begin
            chk("R3 failed flag", alloc_failed, 0);
            chk("R3 pnum", alloc_pnum, pn);
            chk("R3 first page", alloc_page, pg);
        end else begin
            chk("R4 failed flag", alloc_failed, 1);
        end
        chk("R12 free pages", free_pages, m_free());
        @(negedge clk);
        chk("R5 done holds", alloc_done, 1);
        alloc_ack = 1;
        @(negedge clk);
        alloc_ack = 0;
        chk("R5 done cleared", alloc_done, 0);
    endtask

    task automatic txd(input bit ok);
        @(negedge clk); tx_done = 1; tx_ok = ok;
        @(negedge clk); tx_done = 0; tx_ok = 0;
    endtask

    task automatic rxp(input int pn);
        @(negedge clk); rx_push = 1; rx_push_pnum = 6'(pn);
        @(negedge clk); rx_push = 0;
    endtask

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 alloc_done", alloc_done, 0);
        chk("R1 free", free_pages, NP);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_empty", tx_empty, 1);

        // sweep of sizes from empty buffer, R3 R4 R6
        for (int need = 1; need <= 20; need++) begin
            alloc_chk(need);
            cmd(2, 0, 0);
            m_clear();
            chk("R6 reset frees all", free_pages, NP);
        end

        // R2 busy window and ignored command
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_pages = 5'd1;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_pages = 5'd4;
        chk("R2 busy c1", busy, 1);
        @(negedge clk);
        cmd_valid = 0;
        chk("R2 busy c2", busy, 1);
        @(negedge clk); chk("R2 busy c3", busy, 1);
        @(negedge clk); chk("R2 busy c4", busy, 1);
        @(negedge clk); chk("R2 idle after 4", busy, 0);
        chk("R2 second cmd ignored", free_pages, NP - 2);
        alloc_ack = 1; @(negedge clk); alloc_ack = 0;
        cmd(2, 0, 0);
        m_clear();

        // first-fit fragmentation R3 R4 R7 R12
        alloc_chk(2); alloc_chk(3); alloc_chk(4); alloc_chk(5);
        cmd(4, 0, 1); m_release(1);
        chk("R7 free pkt", free_pages, m_free());
        alloc_chk(4);
        alloc_chk(3);
        alloc_chk(1);
        cmd(4, 0, 10);
        chk("R7 unallocated ignored", free_pages, m_free());
        cmd(4, 0, 30);
        chk("R7 out of range ignored", free_pages, m_free());

        // transmit queue R9 R10
        cmd(5, 0, 0); cmd(5, 0, 2); cmd(5, 0, 3);
        cmd(5, 0, 12);
        chk("R9 tx head", tx_head_pnum, 0);
        auto_release = 1;
        txd(1); m_release(0);
        chk("R10 auto freed", free_pages, m_free());
        chk("R9 tx next", tx_head_pnum, 2);
        txd(0);
        chk("R10 failed kept", free_pages, m_free());
        chk("R10 done pnum", tx_done_pnum, 2);
        auto_release = 0;
        txd(1);
        chk("R10 no auto kept", free_pages, m_free());
        chk("R10 done pnum2", tx_done_pnum, 3);
        chk("R9 unallocated not queued", tx_empty, 1);
        cmd(4, 0, 3); m_release(3);
        chk("R7 host free", free_pages, m_free());

        // receive queue R8 R11
        rxp(1); rxp(4);
        chk("R11 rx head", rx_head_pnum, 1);
        chk("R11 rx nonempty", rx_empty, 0);
        cmd(3, 0, 0); m_release(1);
        chk("R8 release frees", free_pages, m_free());
        chk("R11 rx next", rx_head_pnum, 4);
        cmd(3, 0, 0); m_release(4);
        chk("R8 release frees2", free_pages, m_free());
        chk("R8 rx empty", rx_empty, 1);
        cmd(3, 0, 0);
        chk("R8 empty release ignored", free_pages, m_free());

        // reset clears queues R6
        cmd(5, 0, 2); rxp(2);
        cmd(2, 0, 0); m_clear();
        chk("R6 tx flushed", tx_empty, 1);
        chk("R6 rx flushed", rx_empty, 1);
        chk("R6 free", free_pages, NP);
        alloc_chk(18);
        alloc_chk(1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule